// File: doc/BRIEF.md
# Viterbi Traceback Survivor Memory

This block sits behind the add-compare-select stage of a rate-1/2, constraint-length-7 Viterbi decoder (generators 171 and 133 octal, 64 trellis states). The block takes one 64-bit decision vector per trellis step and stores it in a circular survivor store. The store is split into two 32-bit banks, so each step occupies one word in each bank. After every block of new steps, the block chains backwards through the stored decisions and emits the recovered information bits in time order.

Each traceback pass starts at the step that was just written. It runs 96 steps to converge onto the survivor path, then 32 more steps whose bits it keeps. A reversal register turns those backward-order bits into a forward-order serial stream. The starting state is either state 0, for zero-terminated streams, or a best-metric state supplied by the metric stage. The store holds 256 steps, so the writes that arrive during a pass never reach the steps that the pass is reading.

The block assumes that steps arrive at most one every five clock cycles. This lets a 128-cycle pass finish before the next one is triggered.

Top module: `tbk_survivor_mem`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` is low after that edge. The fill and walk state are cleared, so no block appears until the store has been refilled.
- R2: No decoded bit is produced before 128 steps have been stored. Storing the 128th step triggers the first pass.
- R3: Every further 32 stored steps trigger one pass. Each pass releases exactly 32 bits, on 32 consecutive cycles with `out_valid` high.
- R4: Decoded bits leave in time order. The concatenated output equals the information bits, starting from the first step stored after reset. The bit decoded at a step is bit 5 of the survivor state at that step.
- R5: A walk step from state s goes to {s[4:0], d}. Here d is bit s of the stored `dec_vec` for that step: bits 31..0 (states 0–31) sit in bank word 0 and bits 63..32 sit in bank word 1.
- R6: With `zero_term` low, the pass starts at `best_state` as sampled with the triggering step.
- R7: With `zero_term` high, the pass starts at state 0, and `best_state` has no effect on the output.
- R8: The first 96 steps of each pass produce no output. When every path merges within that window, the chosen start state does not change the output.
- R9: The first `out_valid` of a block appears 128 clock edges after the edge that stores the triggering step.
- R10: Steps written while a pass is running do not disturb it. The store keeps 256 steps (at least 96 + 2×32), so output stays correct under continuous input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | A decision vector for one trellis step is present |
| dec_vec | input | 64 | Decision bit of each state; bit s belongs to state s |
| zero_term | input | 1 | Start the pass from state 0 instead of `best_state` |
| best_state | input | 6 | Best-metric state of the step being stored |
| out_valid | output | 1 | A decoded bit is present |
| out_bit | output | 1 | Decoded information bit, oldest first |

## Verification
On every cycle, assertions check the following scheduling rules: a pass is never triggered while another is walking, a triggered pass starts on the next cycle and ends cleanly, a finished block never overwrites bits still being shifted out, and no output appears before the store has been primed. Only the bench scenarios can show that the survivor chain is followed correctly. These scenarios cover the start-state choice in each mode, convergence from an arbitrary state, the time ordering of released bits, the exact priming and latency boundaries, and the absence of corruption from concurrent writes.

// File: rtl/tbk_pkg.sv
// Package: shared types for the traceback survivor memory.
// Assumes: nothing beyond standard SystemVerilog.
package tbk_pkg;
    // Phase of the traceback walker.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WALK = 1'b1
    } walk_phase_e;
endpackage

// File: rtl/tbk_store.sv
// Module: tbk_store
// Holds the per-step decision vectors in banks of WORD_BITS-bit words. The
// high state bits pick the bank and the low bits pick the bit within the word.
// Assumes: STATE_BITS exceeds log2(WORD_BITS); read is asynchronous, and a
// location written at an edge is readable in the following cycle.
module tbk_store #(
    parameter int STATE_BITS = 6,
    parameter int WORD_BITS  = 32,
    parameter int ADDR_BITS  = 8
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [ADDR_BITS-1:0]        wr_addr,
    input  logic [(1<<STATE_BITS)-1:0]  wr_vec,
    input  logic [ADDR_BITS-1:0]        rd_addr,
    input  logic [STATE_BITS-1:0]       rd_state,
    output logic                        rd_bit
);
    localparam int NSTATE   = 1 << STATE_BITS;
    localparam int NBANK    = NSTATE / WORD_BITS;
    localparam int SEL_BITS = $clog2(WORD_BITS);
    localparam int NSTEP    = 1 << ADDR_BITS;

    logic [NBANK-1:0] bank_bit;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [WORD_BITS-1:0] mem [NSTEP];

        // Store this bank's slice of the decision vector.
        always_ff @(posedge clk) begin
            if (wr_en) mem[wr_addr] <= wr_vec[b*WORD_BITS +: WORD_BITS];
        end

        // Pick the decision bit of the addressed state from this bank.
        assign bank_bit[b] = mem[rd_addr][rd_state[SEL_BITS-1:0]];
    end

    assign rd_bit = bank_bit[rd_state[STATE_BITS-1:SEL_BITS]];
endmodule

// File: rtl/tbk_ctrl.sv
// Module: tbk_ctrl
// Advances the circular write pointer, tracks how many steps have been
// stored, and triggers a traceback once the store is primed and at every
// BLOCK-th step after that.
// Assumes: DEPTH is a multiple of BLOCK.
module tbk_ctrl #(
    parameter int ADDR_BITS = 8,
    parameter int DEPTH     = 96,
    parameter int BLOCK     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dec_valid,
    output logic [ADDR_BITS-1:0] wr_ptr,
    output logic                 tb_start,
    output logic                 primed
);
    localparam int PRIME  = DEPTH + BLOCK;
    localparam int FILL_W = $clog2(PRIME + 1);
    localparam int BLK_W  = $clog2(BLOCK);

    logic [FILL_W-1:0] fill_q;
    logic [BLK_W-1:0]  blk_q;

    assign tb_start = dec_valid && (fill_q >= FILL_W'(PRIME - 1))
                      && (blk_q == BLK_W'(BLOCK - 1));
    assign primed   = (fill_q == FILL_W'(PRIME));

    // Step the pointer, the saturating fill count and the block phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            fill_q <= '0;
            blk_q  <= '0;
        end else if (dec_valid) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (!primed) fill_q <= fill_q + 1'b1;
            blk_q  <= (blk_q == BLK_W'(BLOCK - 1)) ? '0 : blk_q + 1'b1;
        end
    end
endmodule

// File: rtl/tbk_walker.sv
// Module: tbk_walker
// Chains backwards one trellis step per cycle for DEPTH+BLOCK steps. It
// starts at the step just written and marks the last BLOCK steps for output,
// together with their forward-order index.
// Assumes: a new start never arrives while a walk is in progress.
module tbk_walker
    import tbk_pkg::*;
#(
    parameter int STATE_BITS = 6,
    parameter int ADDR_BITS  = 8,
    parameter int DEPTH      = 96,
    parameter int BLOCK      = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [ADDR_BITS-1:0]       start_ptr,
    input  logic [STATE_BITS-1:0]      start_state,
    input  logic                       rd_bit,
    output logic [ADDR_BITS-1:0]       rd_addr,
    output logic [STATE_BITS-1:0]      rd_state,
    output logic                       busy,
    output logic                       emit,
    output logic                       emit_bit,
    output logic [$clog2(BLOCK)-1:0]   emit_idx,
    output logic                       done
);
    localparam int WALK  = DEPTH + BLOCK;
    localparam int CNT_W = $clog2(WALK);
    localparam int IDX_W = $clog2(BLOCK);

    walk_phase_e          phase_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [ADDR_BITS-1:0] ptr_q;
    logic [STATE_BITS-1:0] cur_q;
    logic [CNT_W-1:0]     back;

    assign busy     = (phase_q == PH_WALK);
    assign rd_addr  = ptr_q;
    assign rd_state = cur_q;
    assign back     = CNT_W'(WALK - 1) - cnt_q;
    assign emit     = busy && (cnt_q >= CNT_W'(DEPTH));
    assign emit_bit = cur_q[STATE_BITS-1];
    assign emit_idx = back[IDX_W-1:0];
    assign done     = busy && (cnt_q == CNT_W'(WALK - 1));

    // Load a new walk or move one step back along the survivor chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            ptr_q   <= '0;
            cur_q   <= '0;
        end else if (phase_q == PH_IDLE) begin
            if (start) begin
                phase_q <= PH_WALK;
                cnt_q   <= '0;
                ptr_q   <= start_ptr;
                cur_q   <= start_state;
            end
        end else begin
            cur_q <= {cur_q[STATE_BITS-2:0], rd_bit};
            ptr_q <= ptr_q - 1'b1;
            cnt_q <= cnt_q + 1'b1;
            if (done) phase_q <= PH_IDLE;
        end
    end

    // R3
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    // R9
    walk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy && (cnt_q == '0));
    // R9
    walk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/tbk_reverse.sv
// Module: tbk_reverse
// Collects the bits marked for output, which arrive in backward order, at
// their forward-order positions. When a walk finishes, it hands the block to
// a shifter that emits it oldest bit first.
// Assumes: a block is finished only after the previous one has drained.
module tbk_reverse #(
    parameter int BLOCK = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     emit,
    input  logic                     emit_bit,
    input  logic [$clog2(BLOCK)-1:0] emit_idx,
    input  logic                     done,
    output logic                     out_valid,
    output logic                     out_bit
);
    localparam int OCNT_W = $clog2(BLOCK + 1);

    logic [BLOCK-1:0]  collect_q;
    logic [BLOCK-1:0]  collect_nx;
    logic [BLOCK-1:0]  shift_q;
    logic [OCNT_W-1:0] ocnt_q;

    assign out_valid = (ocnt_q != '0);
    assign out_bit   = shift_q[0];

    // Place the incoming bit at its forward-order slot.
    always_comb begin
        collect_nx = collect_q;
        if (emit) collect_nx[emit_idx] = emit_bit;
    end

    // Keep the collection and run the output shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            collect_q <= '0;
            shift_q   <= '0;
            ocnt_q    <= '0;
        end else begin
            collect_q <= collect_nx;
            if (done) begin
                shift_q <= collect_nx;
                ocnt_q  <= OCNT_W'(BLOCK);
            end else if (out_valid) begin
                shift_q <= shift_q >> 1;
                ocnt_q  <= ocnt_q - 1'b1;
            end
        end
    end

    // R3
    no_clobber_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ocnt_q == '0));
endmodule

// File: rtl/tbk_survivor_mem.sv
// Module: tbk_survivor_mem (top)
// Survivor memory and traceback of the Viterbi decoder. It stores one
// decision vector per trellis step and releases one forward-ordered block of
// decoded bits per BLOCK steps, once DEPTH+BLOCK steps have been stored.
// Assumes: steps arrive at most one every five cycles with the default sizes
// (BLOCK spaced steps must take longer than DEPTH+BLOCK cycles).
module tbk_survivor_mem #(
    parameter int STATE_BITS = 6,
    parameter int WORD_BITS  = 32,
    parameter int DEPTH      = 96,
    parameter int BLOCK      = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        dec_valid,
    input  logic [(1<<STATE_BITS)-1:0]  dec_vec,
    input  logic                        zero_term,
    input  logic [STATE_BITS-1:0]       best_state,
    output logic                        out_valid,
    output logic                        out_bit
);
    localparam int ADDR_BITS = $clog2(DEPTH + 2 * BLOCK);
    localparam int IDX_W     = $clog2(BLOCK);

    logic [ADDR_BITS-1:0]  wr_ptr;
    logic                  tb_start;
    logic                  primed;
    logic [ADDR_BITS-1:0]  rd_addr;
    logic [STATE_BITS-1:0] rd_state;
    logic                  rd_bit;
    logic                  busy;
    logic                  emit;
    logic                  emit_bit;
    logic [IDX_W-1:0]      emit_idx;
    logic                  done;
    logic [STATE_BITS-1:0] start_state;

    // Terminated streams end in state 0; otherwise follow the metric stage.
    assign start_state = zero_term ? '0 : best_state;

    tbk_ctrl #(.ADDR_BITS(ADDR_BITS), .DEPTH(DEPTH), .BLOCK(BLOCK)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid),
        .wr_ptr(wr_ptr), .tb_start(tb_start), .primed(primed)
    );

    tbk_store #(.STATE_BITS(STATE_BITS), .WORD_BITS(WORD_BITS),
                .ADDR_BITS(ADDR_BITS)) u_store (
        .clk(clk), .wr_en(dec_valid), .wr_addr(wr_ptr), .wr_vec(dec_vec),
        .rd_addr(rd_addr), .rd_state(rd_state), .rd_bit(rd_bit)
    );

    tbk_walker #(.STATE_BITS(STATE_BITS), .ADDR_BITS(ADDR_BITS),
                 .DEPTH(DEPTH), .BLOCK(BLOCK)) u_walker (
        .clk(clk), .rst_n(rst_n), .start(tb_start), .start_ptr(wr_ptr),
        .start_state(start_state), .rd_bit(rd_bit), .rd_addr(rd_addr),
        .rd_state(rd_state), .busy(busy), .emit(emit), .emit_bit(emit_bit),
        .emit_idx(emit_idx), .done(done)
    );

    tbk_reverse #(.BLOCK(BLOCK)) u_reverse (
        .clk(clk), .rst_n(rst_n), .emit(emit), .emit_bit(emit_bit),
        .emit_idx(emit_idx), .done(done), .out_valid(out_valid),
        .out_bit(out_bit)
    );

    // R2
    early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || busy) |-> primed);
endmodule

// File: tb/tbk_survivor_mem_bench.sv
// Bench for tbk_survivor_mem. It builds decision vectors from known
// information bits, walks a scenario table, then runs directed reset and
// priming tests.
module tbk_survivor_mem_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic [63:0] dec_vec = '0;
    logic        zero_term = 1'b0;
    logic [5:0]  best_state = '0;
    logic        out_valid;
    logic        out_bit;

    always #4 clk = ~clk;

    tbk_survivor_mem u_tbk_survivor_mem (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_vec(dec_vec),
        .zero_term(zero_term), .best_state(best_state),
        .out_valid(out_valid), .out_bit(out_bit)
    );

    // Scenario table: kind, steps, seed, expected bit count, expected latency.
    // kind 0: all states point to the true predecessor (R8), random start.
    // kind 1: only the true state is right, start from best_state (R6).
    // kind 2: zero-terminated blocks, random best_state ignored (R7).
    localparam int N_SC = 4;
    localparam int SC_KIND [N_SC] = '{0, 1, 2, 1};
    localparam int SC_STEPS[N_SC] = '{160, 224, 192, 128};
    localparam int SC_SEED [N_SC] = '{32'h1234, 32'h9e37, 32'h5a5a, 32'h0bad};
    localparam int SC_NOUT [N_SC] = '{64, 128, 96, 32};
    localparam int SC_LAT  [N_SC] = '{128, 128, 128, 128};
    localparam int GAP = 5;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int unsigned rng = 1;
    bit u [512];
    bit got [512];
    int got_n, run_len, bad_runs, first_cyc;
    int trig_cyc;

    always @(posedge clk) cyc <= cyc + 1;

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            got_n = 0; run_len = 0; bad_runs = 0; first_cyc = -1;
        end else if (out_valid) begin
            if (got_n < 512) got[got_n] = out_bit;
            got_n++;
            if (first_cyc < 0) first_cyc = cyc;
            run_len++;
        end else if (run_len != 0) begin
            if (run_len != 32) bad_runs++;
            run_len = 0;
        end
    end

    function automatic bit rbit();
        rng ^= rng << 13;
        rng ^= rng >> 17;
        rng ^= rng << 5;
        return rng[7];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; dec_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic bit ubit(input int t);
        return (t >= 0) ? u[t] : 1'b0;
    endfunction

    // Store steps t0..t1-1 of the prepared bit sequence.
    task automatic feed(input int kind, input int t0, input int t1);
        for (int t = t0; t < t1; t++) begin
            logic [5:0] ts;
            for (int k = 0; k < 6; k++) ts[5-k] = ubit(t - k);
            for (int s = 0; s < 64; s++)
                dec_vec[s] = (kind == 0 || s == int'(ts)) ? ubit(t - 6) : rbit();
            zero_term  = (kind == 2);
            best_state = (kind == 1) ? ts : {rbit(), rbit(), rbit(), rbit(), rbit(), rbit()};
            dec_valid  = 1'b1;
            @(negedge clk);
            dec_valid  = 1'b0;
            if (t + 1 == 128) trig_cyc = cyc;
            repeat (GAP - 1) @(negedge clk);
        end
    endtask

    task automatic make_bits(input int kind, input int n);
        for (int t = 0; t < n; t++)
            u[t] = (kind == 2 && (t % 32) >= 26) ? 1'b0 : rbit();
    endtask

    task automatic compare_bits(input string req, input int n);
        for (int k = 0; k < n; k++)
            check(got[k] == u[k], req, int'(got[k]), int'(u[k]));
    endtask

    initial begin : watchdog
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: idle after reset.
        @(negedge clk);
        check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);

        // Scenario table walk.
        for (int i = 0; i < N_SC; i++) begin
            string req;
            req = (SC_KIND[i] == 0) ? "R4/R5/R8/R10" :
                  (SC_KIND[i] == 1) ? "R4/R5/R6/R10" : "R4/R5/R7/R10";
            rng = SC_SEED[i];
            do_reset();
            make_bits(SC_KIND[i], SC_STEPS[i]);
            feed(SC_KIND[i], 0, SC_STEPS[i]);
            repeat (200) @(negedge clk);
            check(got_n == SC_NOUT[i], "R3 bit count", got_n, SC_NOUT[i]);
            check(bad_runs == 0 && run_len == 0, "R3 block run length", bad_runs, 0);
            check(first_cyc - trig_cyc == SC_LAT[i], "R9 latency", first_cyc - trig_cyc, SC_LAT[i]);
            compare_bits(req, SC_NOUT[i]);
        end

        // R2: 127 steps give nothing; the 128th releases the first block.
        rng = 32'h7777;
        do_reset();
        make_bits(1, 128);
        feed(1, 0, 127);
        repeat (400) @(negedge clk);
        check(got_n == 0, "R2 no output at 127 steps", got_n, 0);
        feed(1, 127, 128);
        repeat (200) @(negedge clk);
        check(got_n == 32, "R2 first block at 128 steps", got_n, 32);
        compare_bits("R2/R4", 32);

        // R1: reset while a block is being shifted out.
        rng = 32'h4242;
        do_reset();
        make_bits(1, 128);
        feed(1, 0, 128);
        repeat (130) @(negedge clk);
        check(out_valid == 1'b1, "R1 block in progress", int'(out_valid), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 reset mid-block", int'(out_valid), 0);
        rst_n = 1'b1;
        repeat (300) @(negedge clk);
        check(got_n == 0, "R1 no stale block", got_n, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule